// File: doc/BRIEF.md
# Quadrature-Locked Resonant Gate Driver

This block produces the two complementary gate drives of a current-fed push-pull resonant converter and keeps their timing aligned with the tank. A phase accumulator produces an overflow tick at four times the switching rate. A two-stage quarter-step divider turns those ticks into the switching square wave and a second copy that leads it by a quarter period.

A comparator outside the block squares the resonant voltage and presents it as a single bit. That bit is resynchronised and compared with the switching wave through an exclusive-OR. The comparison output drives a clamped integrator that moves the accumulator's step word a little above or below a nominal value. The loop settles when the comparison output is high for half of each period, which is the quarter-period offset between drive and tank.

A lock monitor looks at every switching period. It reports lock once a chosen number of consecutive periods show a duty close to one half.

Top module: `qpll_gate_drive`

## Requirements
- R1: While reset is held and directly after it is released, gate_a is 0, gate_b is 1, quad_out is 0, locked is 0, and tune_word equals nom_inc.
- R2: gate_b is always the inverse of gate_a.
- R3: The phase accumulator is 10 bits wide. With a constant step word W that divides 1024, gate_a has a period of exactly 4*1024/W clock cycles.
- R4: quad_out has the same period as gate_a and rises exactly one quarter period (1024/W cycles) before each rising edge of gate_a. On each accumulator overflow exactly one of the two divider stages changes.
- R5: res_sq is resynchronised through two flops. The integrator adds loop_gain on each cycle in which the synchronised res_sq differs from gate_a, and subtracts it otherwise. tune_word equals nom_inc plus the integrator shifted right arithmetically by 4, saturated to 1..1023. With loop_gain 0, tune_word stays at nom_inc whatever res_sq does.
- R6: The integrator is clamped to -1023..+1023, so tune_word stays within nom_inc-64..nom_inc+63, and both limits are reached under a persistent one-sided error.
- R7: At each rising edge of gate_a the monitor measures the period just ended. The period is good when twice its high-comparison count differs from its length by at most 12 cycles. locked rises on the edge that completes lock_periods consecutive good periods, drops on the first bad period, and changes only in the cycle after a rising edge of gate_a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nom_inc | input | 10 | Nominal accumulator step word |
| loop_gain | input | 6 | Integrator step per cycle (unsigned) |
| lock_periods | input | 8 | Consecutive good periods needed for lock |
| res_sq | input | 1 | Squared resonant voltage (asynchronous) |
| gate_a | output | 1 | Drive for the first switch |
| gate_b | output | 1 | Drive for the second switch, inverse of gate_a |
| quad_out | output | 1 | Quarter-period leading copy of gate_a |
| tune_word | output | 10 | Step word currently applied to the accumulator |
| locked | output | 1 | Quadrature lock indication |

## Verification
Every cycle, the embedded properties enforce three things: the single-stage divider steps, the integrator's bounds and its direction of travel, and the rule that lock may only change right after a drive edge. Only the bench scenarios can show the exact periods and quarter-period lead for several step words, the extreme tuning values reached under sustained in-phase and anti-phase reference, and the lock count and its loss. In those scenarios the bench derives the reference from the block's own outputs.

// File: rtl/qpll_pkg.sv
package qpll_pkg;
    localparam int DEF_ACC_W    = 10;
    localparam int DEF_FILT_W   = 12;
    localparam int DEF_GAIN_W   = 6;
    localparam int DEF_LIMIT    = 1023;
    localparam int DEF_SHIFT    = 4;
    localparam int DEF_LOCK_TOL = 12;
    localparam int DEF_PER_W    = 16;
    localparam int LOCK_CNT_W   = 8;

    typedef logic [LOCK_CNT_W-1:0] lock_cnt_t;
endpackage

// File: rtl/qpll_nco.sv
module qpll_nco #(
    parameter int ACC_W = qpll_pkg::DEF_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] inc,
    output logic             sw,
    output logic             quad
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             ph_lead;
        logic             ph_main;
    } nco_t;

    nco_t             st_d, st_q;
    logic [ACC_W:0]   sum;
    logic             carry;

    always_comb begin
        st_d     = st_q;
        sum      = {1'b0, st_q.acc} + {1'b0, inc};
        carry    = sum[ACC_W];
        st_d.acc = sum[ACC_W-1:0];
        // quarter-step Johnson pair: lead takes inverted main, main takes lead
        if (carry) begin
            st_d.ph_lead = ~st_q.ph_main;
            st_d.ph_main = st_q.ph_lead;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sw   = st_q.ph_main;
    assign quad = st_q.ph_lead;

    // R4: each overflow moves exactly one divider stage
    a_r4_one_stage_moves: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> ($countones({st_q.ph_lead, st_q.ph_main} ^
                              $past({st_q.ph_lead, st_q.ph_main})) == 1));
    // R4: no movement without an overflow
    a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !carry |=> $stable({st_q.ph_lead, st_q.ph_main}));
endmodule

// File: rtl/qpll_loop_filter.sv
module qpll_loop_filter #(
    parameter int ACC_W  = qpll_pkg::DEF_ACC_W,
    parameter int FILT_W = qpll_pkg::DEF_FILT_W,
    parameter int GAIN_W = qpll_pkg::DEF_GAIN_W,
    parameter int LIMIT  = qpll_pkg::DEF_LIMIT,
    parameter int SHIFT  = qpll_pkg::DEF_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_sq,
    input  logic              sw,
    input  logic [ACC_W-1:0]  nom_inc,
    input  logic [GAIN_W-1:0] gain,
    output logic              pd,
    output logic [ACC_W-1:0]  tune
);
    localparam int IW    = FILT_W + 1;
    localparam int SUM_W = ((FILT_W > ACC_W) ? FILT_W : ACC_W) + 2;
    localparam logic signed [IW-1:0]    LIM_HI   = IW'(LIMIT);
    localparam logic signed [IW-1:0]    LIM_LO   = -LIM_HI;
    localparam logic signed [SUM_W-1:0] TUNE_MAX = SUM_W'((1 << ACC_W) - 1);
    localparam logic signed [SUM_W-1:0] TUNE_MIN = SUM_W'(1);

    typedef struct packed {
        logic                     s1;
        logic                     s2;
        logic signed [FILT_W-1:0] integ;
    } filt_t;

    filt_t                    st_d, st_q;
    logic signed [IW-1:0]     step, cur, nxt;
    logic signed [SUM_W-1:0]  offs, tsum;
    logic signed [FILT_W-1:0] integ_q;

    assign integ_q = st_q.integ;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = res_sq;
        st_d.s2 = st_q.s1;
        pd      = sw ^ st_q.s2;
        step    = $signed(IW'(gain));
        cur     = IW'(integ_q);
        nxt     = pd ? (cur + step) : (cur - step);
        if (nxt > LIM_HI)      nxt = LIM_HI;
        else if (nxt < LIM_LO) nxt = LIM_LO;
        st_d.integ = FILT_W'(nxt);
        offs = SUM_W'(integ_q >>> SHIFT);
        tsum = $signed(SUM_W'(nom_inc)) + offs;
        if (tsum > TUNE_MAX)      tsum = TUNE_MAX;
        else if (tsum < TUNE_MIN) tsum = TUNE_MIN;
        tune = tsum[ACC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: integrator never leaves its window
    a_r6_integ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (integ_q <= $signed(FILT_W'(LIMIT))) && (integ_q >= -$signed(FILT_W'(LIMIT))));
    // R5: a high comparison never lowers the integrator
    a_r5_up_when_high: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> (integ_q >= $past(integ_q)));
    // R5: a low comparison never raises it
    a_r5_down_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pd |=> (integ_q <= $past(integ_q)));
endmodule

// File: rtl/qpll_lock_det.sv
module qpll_lock_det #(
    parameter int PER_W = qpll_pkg::DEF_PER_W,
    parameter int TOL   = qpll_pkg::DEF_LOCK_TOL,
    parameter int CNT_W = qpll_pkg::LOCK_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw,
    input  logic             pd,
    input  logic [CNT_W-1:0] need,
    output logic             locked
);
    localparam int DW = PER_W + 2;
    localparam logic [PER_W-1:0]     PER_MAX = '1;
    localparam logic [CNT_W-1:0]     CNT_MAX = '1;
    localparam logic signed [DW-1:0] TOL_V   = DW'(TOL);

    typedef struct packed {
        logic             sw_prev;
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] hi;
        logic [CNT_W-1:0] good;
        logic             locked;
    } lock_t;

    lock_t                st_d, st_q;
    logic                 rise, in_tol, locked_q;
    logic signed [DW-1:0] diff, mag;

    assign locked_q = st_q.locked;

    always_comb begin
        st_d         = st_q;
        st_d.sw_prev = sw;
        rise   = sw & ~st_q.sw_prev;
        diff   = $signed({1'b0, st_q.hi, 1'b0}) - $signed({2'b00, st_q.per});
        mag    = (diff < 0) ? -diff : diff;
        in_tol = (mag <= TOL_V) && (st_q.per != PER_MAX) && (st_q.per != '0);
        if (rise) begin
            st_d.per = PER_W'(1);
            st_d.hi  = PER_W'(pd);
            if (in_tol) begin
                if (st_q.good != CNT_MAX) st_d.good = st_q.good + CNT_W'(1);
                st_d.locked = ({1'b0, st_q.good} + (CNT_W+1)'(1)) >= {1'b0, need};
            end else begin
                st_d.good   = '0;
                st_d.locked = 1'b0;
            end
        end else begin
            if (st_q.per != PER_MAX)      st_d.per = st_q.per + PER_W'(1);
            if (pd && st_q.hi != PER_MAX) st_d.hi  = st_q.hi + PER_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = locked_q;

    // R7: lock state moves only right after a drive rising edge
    a_r7_lock_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(locked_q));
endmodule

// File: rtl/qpll_gate_drive.sv
module qpll_gate_drive #(
    parameter int ACC_W    = qpll_pkg::DEF_ACC_W,
    parameter int FILT_W   = qpll_pkg::DEF_FILT_W,
    parameter int GAIN_W   = qpll_pkg::DEF_GAIN_W,
    parameter int LIMIT    = qpll_pkg::DEF_LIMIT,
    parameter int SHIFT    = qpll_pkg::DEF_SHIFT,
    parameter int LOCK_TOL = qpll_pkg::DEF_LOCK_TOL,
    parameter int PER_W    = qpll_pkg::DEF_PER_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ACC_W-1:0]                nom_inc,
    input  logic [GAIN_W-1:0]               loop_gain,
    input  logic [qpll_pkg::LOCK_CNT_W-1:0] lock_periods,
    input  logic                            res_sq,
    output logic                            gate_a,
    output logic                            gate_b,
    output logic                            quad_out,
    output logic [ACC_W-1:0]                tune_word,
    output logic                            locked
);
    logic sw, quad, pd;
    logic [ACC_W-1:0] tune;

    qpll_nco #(.ACC_W(ACC_W)) u_nco (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (tune),
        .sw   (sw),
        .quad (quad)
    );

    qpll_loop_filter #(
        .ACC_W (ACC_W),
        .FILT_W(FILT_W),
        .GAIN_W(GAIN_W),
        .LIMIT (LIMIT),
        .SHIFT (SHIFT)
    ) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .res_sq (res_sq),
        .sw     (sw),
        .nom_inc(nom_inc),
        .gain   (loop_gain),
        .pd     (pd),
        .tune   (tune)
    );

    qpll_lock_det #(
        .PER_W(PER_W),
        .TOL  (LOCK_TOL),
        .CNT_W(qpll_pkg::LOCK_CNT_W)
    ) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .sw    (sw),
        .pd    (pd),
        .need  (lock_periods),
        .locked(locked)
    );

    assign gate_a    = sw;
    assign gate_b    = ~sw;
    assign quad_out  = quad;
    assign tune_word = tune;

    // R4: the leading copy is already high whenever the main drive rises
    a_r4_lead_before_main: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_a) |-> quad_out);
endmodule

// File: tb/qpll_gate_drive_test.sv
module qpll_gate_drive_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] nom_inc = 10'd64;
    logic [5:0] loop_gain = 6'd0;
    logic [7:0] lock_periods = 8'd8;
    logic       res_const = 1'b0;
    int         res_mode = 0;
    logic       res_sq, gate_a, gate_b, quad_out, locked;
    logic [9:0] tune_word;
    int         n_checks = 0;
    int         n_err = 0;
    int         cyc = 0;

    localparam int NVEC = 4;
    localparam int VEC_INC [NVEC] = '{32, 64, 128, 256};
    localparam int VEC_PER [NVEC] = '{128, 64, 32, 16};

    always #10 clk = ~clk;

    assign res_sq = (res_mode == 1) ? gate_a :
                    (res_mode == 2) ? gate_b :
                    (res_mode == 3) ? quad_out : res_const;

    qpll_gate_drive uut (
        .clk(clk), .rst_n(rst_n), .nom_inc(nom_inc), .loop_gain(loop_gain),
        .lock_periods(lock_periods), .res_sq(res_sq), .gate_a(gate_a),
        .gate_b(gate_b), .quad_out(quad_out), .tune_word(tune_word), .locked(locked)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_rise(output int n);
        logic prev;
        prev = gate_a;
        n = 0;
        while (n < 4000) begin
            @(negedge clk);
            n++;
            if (gate_a && !prev) break;
            prev = gate_a;
        end
    endtask

    task automatic wait_quad_rise(output int n);
        logic prev;
        prev = quad_out;
        n = 0;
        while (n < 4000) begin
            @(negedge clk);
            n++;
            if (quad_out && !prev) break;
            prev = quad_out;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        int d, p, q, mx, mn;
        bit stayed;

        // R1: reset state
        nom_inc = 10'd100;
        apply_reset();
        check(gate_a == 1'b0, "R1 gate_a", int'(gate_a), 0);
        check(gate_b == 1'b1, "R1 gate_b", int'(gate_b), 1);
        check(quad_out == 1'b0, "R1 quad_out", int'(quad_out), 0);
        check(locked == 1'b0, "R1 locked", int'(locked), 0);
        check(tune_word == 10'd100, "R1 tune_word", int'(tune_word), 100);

        // R3/R4/R2: vector table of step words and expected periods
        for (int i = 0; i < NVEC; i++) begin
            nom_inc = 10'(VEC_INC[i]);
            loop_gain = 6'd0;
            res_mode = 0;
            apply_reset();
            wait_rise(d);
            wait_rise(p);
            check(p == VEC_PER[i], "R3 period", p, VEC_PER[i]);
            check(gate_b == ~gate_a, "R2 complement", int'(gate_b), int'(~gate_a));
            wait_quad_rise(d);
            wait_rise(q);
            check(q == VEC_PER[i] / 4, "R4 quarter lead", q, VEC_PER[i] / 4);
            check(int'(tune_word) == VEC_INC[i], "R5 gain0 tune", int'(tune_word), VEC_INC[i]);
        end

        // R5: zero gain ignores a persistent anti-phase reference
        nom_inc = 10'd128;
        loop_gain = 6'd0;
        res_mode = 2;
        apply_reset();
        stayed = 1'b1;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (tune_word != 10'd128) stayed = 1'b0;
            if (gate_b == gate_a) stayed = 1'b0;
        end
        check(stayed, "R5 gain0 ignores res_sq", int'(tune_word), 128);

        // R5/R6: anti-phase drives frequency up to the upper limit
        loop_gain = 6'd16;
        res_mode = 2;
        apply_reset();
        repeat (300) @(negedge clk);
        check(tune_word > 10'd128, "R5 up under anti-phase", int'(tune_word), 129);
        mx = 0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (int'(tune_word) > mx) mx = int'(tune_word);
        end
        check(mx == 191, "R6 upper clamp", mx, 191);

        // R5/R6: in-phase drives frequency down to the lower limit
        res_mode = 1;
        apply_reset();
        repeat (300) @(negedge clk);
        check(tune_word < 10'd128, "R5 down under in-phase", int'(tune_word), 127);
        mn = 1024;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (int'(tune_word) < mn) mn = int'(tune_word);
        end
        check(mn == 64, "R6 lower clamp", mn, 64);

        // R7: lock after lock_periods good quadrature periods
        nom_inc = 10'd64;
        loop_gain = 6'd0;
        lock_periods = 8'd8;
        res_mode = 3;
        apply_reset();
        repeat (440) @(negedge clk);
        check(locked == 1'b0, "R7 not yet locked", int'(locked), 0);
        repeat (160) @(negedge clk);
        check(locked == 1'b1, "R7 locked after count", int'(locked), 1);
        res_mode = 2;
        repeat (200) @(negedge clk);
        check(locked == 1'b0, "R7 lock lost", int'(locked), 0);
        lock_periods = 8'd2;
        res_mode = 3;
        repeat (400) @(negedge clk);
        check(locked == 1'b1, "R7 relock short count", int'(locked), 1);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule